// File: doc/BRIEF.md
# Block Cipher Mode Controller

This block sits between a data mover and an iterative 128-bit block cipher engine. It takes one data block at a time through a valid/ready handshake, shapes the cipher's input from the block and a chaining/counter register, starts the engine with a one-cycle start pulse, waits for its done pulse, and then combines the engine's result with the stored block to give the value that is written back. The same chaining register holds the previous cipher result in chained modes and serves as the block counter in counter mode. A running message-authentication value is exposed as a tag at the end of every authentication pass.

Software or a sequencer first loads a configuration: mode, key length, a 256-bit key, the starting chaining/counter value, and a second counter seed for the combined authenticate-then-encrypt mode. In that combined mode the block runs two passes back to back over the same engine: first a chained-MAC pass over the formatted header and payload that ends with the tag, then a counter pass that encrypts the payload starting from the seed. The caller marks the final block of each pass with a flag.

Top module: `cipher_mode_ctrl`

## Requirements
- R1: After reset `outValid`, `tagValid` and `cipStart` are 0, `inReady` is 1 and `tag` is all zeros.
- R2: Mode code 0 (electronic codebook) writes back E(block), where E is the cipher result; mode codes 5, 6 and 7 behave exactly like code 0.
- R3: Mode code 1 (chained MAC) feeds the cipher block XOR chain, stores the result as the new chain value, writes back nothing, and on a block flagged last sets `tag` to the final chain value with a one-cycle `tagValid` pulse.
- R4: Mode code 2 (counter) feeds the cipher the counter register, writes back E(counter) XOR block, and then adds one modulo 2^32 to the counter's low 32 bits (bits 31:0) while bits 127:32 stay unchanged.
- R5: Mode code 3 (output feedback) feeds the cipher the chain value, writes back E(chain) XOR block, and replaces the chain value with E(chain).
- R6: Mode code 4 (combined) runs a chained-MAC pass as in R3 until a last-flagged block, then loads the counter seed and runs counter blocks as in R4 until a last-flagged block, after which it returns to the MAC pass.
- R7: Key-length select 0 means 128 bits and sends key bits 255:128 as zero; select 1 means 192 bits and sends bits 255:192 as zero; selects 2 and 3 send all 256 bits; `cipKeyLen` carries the loaded select.
- R8: Each accepted block produces exactly one `cipStart` pulse one cycle wide, and `inReady` stays low from acceptance until the block is finished.
- R9: `outValid` or `tagValid` rises exactly two clock cycles after the cycle in which `cipDone` is high; the two are never high together.
- R10: A `cfgLoad` pulse while a block is in flight is ignored: the block and the following blocks use the configuration loaded before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgLoad | input | 1 | Load configuration (taken only while idle) |
| modeIn | input | 3 | Mode code |
| keySel | input | 2 | Key-length select |
| keyIn | input | 256 | Cipher key |
| ivIn | input | 128 | Starting chain / counter value |
| ccmCtr | input | 128 | Counter seed for the second combined-mode pass |
| inValid | input | 1 | Data block present |
| inReady | output | 1 | Controller can take a block |
| blkData | input | 128 | Data block |
| blkLast | input | 1 | Block ends the current pass |
| cipStart | output | 1 | Start pulse to the cipher engine |
| cipKeyLen | output | 2 | Key-length select to the engine |
| cipKey | output | 256 | Masked key to the engine |
| cipIn | output | 128 | Block to the engine |
| cipDone | input | 1 | Engine result valid pulse |
| cipOut | input | 128 | Engine result |
| outValid | output | 1 | Write-back block valid pulse |
| outData | output | 128 | Write-back block |
| tagValid | output | 1 | Tag updated pulse |
| tag | output | 128 | Authentication tag |

## Verification
Each block is due at a fixed distance from the engine: the input is arranged one cycle after acceptance, `cipStart` follows in the next cycle, and the write-back or tag appears two cycles after the cycle that carries `cipDone`. The bench measures that two-cycle distance on every result and reads write-back and tag values in the first idle cycle after a block, which is the only cycle the pulses are high. Expected values come from an arithmetic model of each mode driven by a stand-in cipher whose latency depends on the key length.

// File: rtl/cmc_pkg.sv
package cmc_pkg;
  localparam int BLK_W = 128;
  localparam int KEY_W = 256;

  typedef enum logic [2:0] {
    MODE_ECB = 3'd0,
    MODE_MAC = 3'd1,
    MODE_CTR = 3'd2,
    MODE_OFB = 3'd3,
    MODE_CCM = 3'd4
  } mode_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ARR, ST_KICK, ST_WAIT, ST_MOD
  } state_e;

  typedef struct packed {
    logic  capCfg;
    logic  capBlk;
    logic  arrange;
    logic  capRes;
    logic  modify;
    logic  emitOut;
    logic  emitTag;
    logic  seedCtr;
    mode_e effMode;
  } strobe_t;
endpackage

// File: rtl/cmc_ctrl.sv
module cmc_ctrl
  import cmc_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cfgLoad,
  input  logic [2:0] modeIn,
  input  logic       inValid,
  input  logic       blkLast,
  input  logic       cipDone,
  output logic       inReady,
  output logic       cipStart,
  output strobe_t    stb
);
  state_e state;
  logic [2:0] modeReg;
  logic lastReg;
  logic ccmPass;
  mode_e eff;

  always_comb begin
    case (modeReg)
      3'd1:    eff = MODE_MAC;
      3'd2:    eff = MODE_CTR;
      3'd3:    eff = MODE_OFB;
      3'd4:    eff = ccmPass ? MODE_CTR : MODE_MAC;
      default: eff = MODE_ECB;
    endcase
  end

  assign inReady  = (state == ST_IDLE) && !cfgLoad;
  assign cipStart = (state == ST_KICK);

  always_comb begin
    stb.capCfg  = (state == ST_IDLE) && cfgLoad;
    stb.capBlk  = inReady && inValid;
    stb.arrange = (state == ST_ARR);
    stb.capRes  = (state == ST_WAIT) && cipDone;
    stb.modify  = (state == ST_MOD);
    stb.emitOut = stb.modify && (eff != MODE_MAC);
    stb.emitTag = stb.modify && (eff == MODE_MAC) && lastReg;
    stb.seedCtr = stb.modify && (modeReg == 3'd4) && !ccmPass && lastReg;
    stb.effMode = eff;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      modeReg <= 3'd0;
      lastReg <= 1'b0;
      ccmPass <= 1'b0;
    end else begin
      if (stb.capCfg) begin
        modeReg <= modeIn;
        ccmPass <= 1'b0;
      end
      if (stb.capBlk) lastReg <= blkLast;
      if (stb.modify && (modeReg == 3'd4) && lastReg) ccmPass <= !ccmPass;
      case (state)
        ST_IDLE: if (stb.capBlk) state <= ST_ARR;
        ST_ARR:  state <= ST_KICK;
        ST_KICK: state <= ST_WAIT;
        ST_WAIT: if (cipDone) state <= ST_MOD;
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/cmc_datapath.sv
module cmc_datapath
  import cmc_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          stb,
  input  logic [1:0]       keySel,
  input  logic [KEY_W-1:0] keyIn,
  input  logic [BLK_W-1:0] ivIn,
  input  logic [BLK_W-1:0] ccmCtr,
  input  logic [BLK_W-1:0] blkData,
  input  logic [BLK_W-1:0] cipOut,
  output logic [1:0]       cipKeyLen,
  output logic [KEY_W-1:0] cipKey,
  output logic [BLK_W-1:0] cipIn,
  output logic             outValid,
  output logic [BLK_W-1:0] outData,
  output logic             tagValid,
  output logic [BLK_W-1:0] tag
);
  localparam int HALF_W = KEY_W / 2;
  localparam int MID_W  = HALF_W + HALF_W / 2;

  logic [BLK_W-1:0] dataReg, ivReg, seedReg, resReg, cinReg;
  logic [KEY_W-1:0] keyMask;

  always_comb begin
    case (keySel)
      2'd0:    keyMask = {KEY_W{1'b1}} >> (KEY_W - HALF_W);
      2'd1:    keyMask = {KEY_W{1'b1}} >> (KEY_W - MID_W);
      default: keyMask = {KEY_W{1'b1}};
    endcase
  end

  assign cipIn = cinReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dataReg   <= '0;
      ivReg     <= '0;
      seedReg   <= '0;
      resReg    <= '0;
      cinReg    <= '0;
      cipKey    <= '0;
      cipKeyLen <= 2'd0;
      outValid  <= 1'b0;
      outData   <= '0;
      tagValid  <= 1'b0;
      tag       <= '0;
    end else begin
      outValid <= stb.emitOut;
      tagValid <= stb.emitTag;
      if (stb.capCfg) begin
        cipKey    <= keyIn & keyMask;
        cipKeyLen <= keySel;
        ivReg     <= ivIn;
        seedReg   <= ccmCtr;
      end
      if (stb.capBlk) dataReg <= blkData;
      if (stb.arrange) begin
        case (stb.effMode)
          MODE_ECB: cinReg <= dataReg;
          MODE_MAC: cinReg <= dataReg ^ ivReg;
          default:  cinReg <= ivReg;
        endcase
      end
      if (stb.capRes) resReg <= cipOut;
      if (stb.modify) begin
        if (stb.effMode == MODE_ECB) outData <= resReg;
        else if (stb.emitOut)        outData <= resReg ^ dataReg;
        if (stb.emitTag) tag <= resReg;
        if (stb.seedCtr)
          ivReg <= seedReg;
        else if (stb.effMode == MODE_CTR)
          ivReg[CNT_W-1:0] <= ivReg[CNT_W-1:0] + 1'b1;
        else if (stb.effMode != MODE_ECB)
          ivReg <= resReg;
      end
    end
  end
endmodule

// File: rtl/cipher_mode_ctrl.sv
module cipher_mode_ctrl
  import cmc_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgLoad,
  input  logic [2:0]       modeIn,
  input  logic [1:0]       keySel,
  input  logic [KEY_W-1:0] keyIn,
  input  logic [BLK_W-1:0] ivIn,
  input  logic [BLK_W-1:0] ccmCtr,
  input  logic             inValid,
  output logic             inReady,
  input  logic [BLK_W-1:0] blkData,
  input  logic             blkLast,
  output logic             cipStart,
  output logic [1:0]       cipKeyLen,
  output logic [KEY_W-1:0] cipKey,
  output logic [BLK_W-1:0] cipIn,
  input  logic             cipDone,
  input  logic [BLK_W-1:0] cipOut,
  output logic             outValid,
  output logic [BLK_W-1:0] outData,
  output logic             tagValid,
  output logic [BLK_W-1:0] tag
);
  strobe_t stb;

  cmc_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .cfgLoad(cfgLoad), .modeIn(modeIn),
    .inValid(inValid), .blkLast(blkLast), .cipDone(cipDone),
    .inReady(inReady), .cipStart(cipStart), .stb(stb)
  );

  cmc_datapath #(.CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .keySel(keySel), .keyIn(keyIn),
    .ivIn(ivIn), .ccmCtr(ccmCtr), .blkData(blkData), .cipOut(cipOut),
    .cipKeyLen(cipKeyLen), .cipKey(cipKey), .cipIn(cipIn),
    .outValid(outValid), .outData(outData), .tagValid(tagValid), .tag(tag)
  );
endmodule

// File: rtl/cmc_checker.sv
module cmc_checker (
  input logic         clk,
  input logic         rstN,
  input logic         inReady,
  input logic         cipStart,
  input logic [1:0]   cipKeyLen,
  input logic [255:0] cipKey,
  input logic         cipDone,
  input logic         outValid,
  input logic         tagValid
);
  // R8
  start_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    cipStart |=> !cipStart);
  // R8
  start_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    cipStart |-> !inReady);
  // R7
  key128_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cipKeyLen == 2'd0) |-> (cipKey[255:128] == '0));
  // R7
  key192_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cipKeyLen == 2'd1) |-> (cipKey[255:192] == '0));
  // R9
  out_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(outValid && tagValid));
  // R9
  out_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outValid || tagValid) |=> !(outValid || tagValid));
  // R9
  done_to_out_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outValid || tagValid) |-> $past(cipDone, 2));
endmodule

bind cipher_mode_ctrl cmc_checker u_cmc_checker (
  .clk(clk), .rstN(rstN), .inReady(inReady), .cipStart(cipStart),
  .cipKeyLen(cipKeyLen), .cipKey(cipKey), .cipDone(cipDone),
  .outValid(outValid), .tagValid(tagValid)
);

// File: tb/test_cipher_mode_ctrl.sv
module test_cipher_mode_ctrl;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cfgLoad = 1'b0;
  logic [2:0] modeIn = '0;
  logic [1:0] keySel = '0;
  logic [255:0] keyIn = '0;
  logic [127:0] ivIn = '0, ccmCtr = '0, blkData = '0;
  logic inValid = 1'b0, blkLast = 1'b0;
  logic inReady, cipStart, outValid, tagValid;
  logic [1:0] cipKeyLen;
  logic [255:0] cipKey;
  logic [127:0] cipIn, outData, tag;
  logic cipDone;
  logic [127:0] cipOut;

  int errors = 0, checks = 0, cyc = 0, doneCyc = -100, startCnt = 0;
  logic [255:0] seenKey;

  always #4 clk = ~clk;

  cipher_mode_ctrl i_cipher_mode_ctrl (
    .clk(clk), .rstN(rstN), .cfgLoad(cfgLoad), .modeIn(modeIn), .keySel(keySel),
    .keyIn(keyIn), .ivIn(ivIn), .ccmCtr(ccmCtr), .inValid(inValid),
    .inReady(inReady), .blkData(blkData), .blkLast(blkLast),
    .cipStart(cipStart), .cipKeyLen(cipKeyLen), .cipKey(cipKey), .cipIn(cipIn),
    .cipDone(cipDone), .cipOut(cipOut), .outValid(outValid), .outData(outData),
    .tagValid(tagValid), .tag(tag)
  );

  function automatic logic [127:0] enc(logic [127:0] x, logic [255:0] k, logic [1:0] kl);
    return {x[94:0], x[127:95]} ^ k[127:0] ^ k[255:128] ^ {126'd0, kl};
  endfunction

  // stand-in cipher: latency 44/52/60 by key length
  logic busy = 1'b0;
  int cnt = 0;
  logic [127:0] held;
  always @(posedge clk) begin
    cyc <= cyc + 1;
    cipDone <= 1'b0;
    if (!rstN) begin
      busy <= 1'b0;
      cipOut <= '0;
    end else if (cipStart) begin
      busy <= 1'b1;
      cnt <= 43 + 8 * ((cipKeyLen == 2'd3) ? 2 : int'(cipKeyLen));
      held <= enc(cipIn, cipKey, cipKeyLen);
      seenKey <= cipKey;
      startCnt <= startCnt + 1;
    end else if (busy) begin
      if (cnt == 0) begin
        cipDone <= 1'b1;
        cipOut <= held;
        busy <= 1'b0;
      end else cnt <= cnt - 1;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // R9 distance from done to result
  always @(negedge clk) begin
    if (rstN && cipDone) doneCyc = cyc;
    if (rstN && (outValid || tagValid))
      chk((cyc - doneCyc) == 2, "R9 done-to-result", 128'(cyc - doneCyc), 128'd2);
  end

  task automatic loadCfg(input logic [2:0] m, input logic [1:0] ks, input logic [255:0] k,
                         input logic [127:0] iv, input logic [127:0] seed);
    @(negedge clk);
    cfgLoad = 1'b1; modeIn = m; keySel = ks; keyIn = k; ivIn = iv; ccmCtr = seed;
    @(negedge clk);
    cfgLoad = 1'b0;
  endtask

  logic gotOut, gotTag;
  logic [127:0] gotData, gotTagV;

  task automatic runBlock(input logic [127:0] d, input bit last, input bit midCfg);
    int s0;
    s0 = startCnt;
    @(negedge clk);
    while (!inReady) @(negedge clk);
    inValid = 1'b1; blkData = d; blkLast = last;
    @(negedge clk);
    inValid = 1'b0;
    chk(!inReady, "R8 busy after accept", {127'd0, inReady}, 128'd0);
    if (midCfg) begin
      cfgLoad = 1'b1; modeIn = 3'd2; ivIn = '1;
      @(negedge clk);
      cfgLoad = 1'b0;
    end
    while (!inReady) @(negedge clk);
    gotOut = outValid; gotTag = tagValid; gotData = outData; gotTagV = tag;
    chk(startCnt - s0 == 1, "R8 one start per block", 128'(startCnt - s0), 128'd1);
  endtask

  initial begin : main
    logic [127:0] iv, seed, d, e, expOut;
    logic [255:0] key, km;
    bit pass2;
    int nblk;
    bit last, expO, expT;
    logic [2:0] eff;
    #1;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(!outValid && !tagValid && !cipStart && inReady, "R1 reset outputs",
        {124'd0, outValid, tagValid, cipStart, inReady}, 128'd1);
    chk(tag == '0, "R1 reset tag", tag, '0);

    for (int m = 0; m < 8; m++) begin
      for (int ks = 0; ks < 4; ks++) begin
        key  = {64'hA5A5_0101_5A5A_F0F0 ^ 64'(m), 64'h1234_5678_9ABC_DEF0,
                64'h0F1E_2D3C_4B5A_6978 + 64'(ks), 64'hFEDC_BA98_7654_3210};
        iv   = {96'h0BAD_CAFE_1111_2222_3333_4444, 32'hFFFF_FFFE};
        seed = {96'h5555_6666_7777_8888_9999_AAAA, 32'h0000_0001 * 32'(m)};
        km   = (ks == 0) ? {128'd0, key[127:0]} : (ks == 1) ? {64'd0, key[191:0]} : key;
        loadCfg(3'(m), 2'(ks), key, iv, seed);
        pass2 = 1'b0;
        nblk = (m == 4) ? 5 : 3;
        for (int b = 0; b < nblk; b++) begin
          d = {32'(b * 7 + m), 32'hC0DE_0000 + 32'(ks), 32'h1357_9BDF, 32'(b)};
          last = (b == 2) || (b == 4);
          runBlock(d, last, 1'b0);
          chk(seenKey == km, "R7 key mask", seenKey[255:128], km[255:128]);
          eff = (m == 4) ? (pass2 ? 3'd2 : 3'd1) : (m > 4 ? 3'd0 : 3'(m));
          expO = 1'b0; expT = 1'b0; expOut = '0;
          case (eff)
            3'd0: begin expO = 1; expOut = enc(d, km, 2'(ks)); end
            3'd1: begin
              iv = enc(d ^ iv, km, 2'(ks));
              if (last) begin
                expT = 1;
                chk(gotTagV == iv, (m == 4) ? "R6 combined tag" : "R3 MAC tag", gotTagV, iv);
                if (m == 4) begin iv = seed; pass2 = 1'b1; end
              end
            end
            3'd2: begin
              expO = 1; expOut = enc(iv, km, 2'(ks)) ^ d;
              iv[31:0] = iv[31:0] + 32'd1;
              if (m == 4 && last) pass2 = 1'b0;
            end
            default: begin
              e = enc(iv, km, 2'(ks)); expO = 1; expOut = e ^ d; iv = e;
            end
          endcase
          chk(gotOut == expO && gotTag == expT,
              m == 4 ? "R6 pulses" : m == 1 ? "R3 pulses" : "R2 pulses",
              {126'd0, gotOut, gotTag}, {126'd0, expO, expT});
          if (expO)
            chk(gotData == expOut,
                m == 2 ? "R4 counter out" : m == 3 ? "R5 feedback out" :
                m == 4 ? "R6 counter pass" : "R2 codebook out", gotData, expOut);
        end
      end
    end

    // R10: config pulse during a block is ignored
    key = {128'd0, 128'h0011_2233_4455_6677_8899_AABB_CCDD_EEFF};
    loadCfg(3'd0, 2'd0, key, '0, '0);
    d = 128'h1111_2222_3333_4444_5555_6666_7777_8888;
    runBlock(d, 1'b0, 1'b1);
    chk(gotOut && gotData == enc(d, key, 2'd0), "R10 busy cfg ignored", gotData, enc(d, key, 2'd0));
    d = 128'h9999_0000_AAAA_BBBB_CCCC_DDDD_EEEE_FFFF;
    runBlock(d, 1'b0, 1'b0);
    chk(gotOut && gotData == enc(d, key, 2'd0), "R10 next block old cfg", gotData, enc(d, key, 2'd0));

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule